// File: doc/BRIEF.md
# Binary Point Priority Split Register

This block holds the binary point setting for an interrupt controller. The setting divides an 8-bit interrupt priority into two parts. The upper part is the group priority, which decides whether one interrupt may interrupt another. The lower part is the subpriority, which only orders interrupts inside the same group. Software writes and reads the setting through a simple 32-bit register port. Only the three lowest bits are stored; all other bits read as zero.

From the stored value the block produces a mask that keeps only the group-priority bits. It also compares a pending priority with the current running priority and says whether the pending interrupt may preempt. Lower numbers mean higher urgency.

The number of implemented priority bits is a build parameter. It sets a floor on the binary point. A write below that floor stores the floor instead, and reset loads the floor. The setting 7 turns preemption off completely.

Top module: `bp_split_reg`

## Requirements
- R1: While reset is asserted, and after it is released with no write, the stored field equals the floor, computed as 7 minus PRIO_BITS and limited to no less than 0 (2 for the default PRIO_BITS of 5).
- R2: A write with `wr_en` high stores `wr_data[2:0]` at the next rising clock edge when that value is at or above the floor.
- R3: A write whose `wr_data[2:0]` is below the floor stores the floor.
- R4: Writes ignore `wr_data[31:3]`, and `rd_data[31:3]` is always zero.
- R5: With `rd_en` high, `rd_data` shows the stored field, zero-extended, in the same cycle. With `rd_en` low, `rd_data` is zero.
- R6: For a stored value N from 0 to 6, `grp_mask` has bits [N:0] at 0 and bits [7:N+1] at 1. For N = 7, `grp_mask` is 8'h00.
- R7: `preempt` is high when `pend_prio & grp_mask` is numerically lower than `run_prio & grp_mask` and the stored value is not 7.
- R8: `preempt` is low when the two masked priorities are equal, even if the subpriority bits differ.
- R9: When the stored value is 7, `preempt` is low for any pair of input priorities.
- R10: With `wr_en` low, the stored field keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_en | input | 1 | Register read request |
| rd_data | output | 32 | Register read value (combinational) |
| pend_prio | input | 8 | Priority of the pending interrupt |
| run_prio | input | 8 | Current running priority |
| grp_mask | output | 8 | Mask that keeps the group-priority bits |
| preempt | output | 1 | Pending interrupt may preempt |

## Verification
Only the write path has a register. A write affects `rd_data`, `grp_mask` and `preempt` from the rising edge that captures it, which is one cycle after the write is driven. Reads, the mask and the preemption decision follow their inputs in the same cycle. The bench drives inputs on the falling edge. It lets the capturing rising edge pass before it schedules a check, and then compares the outputs a few nanoseconds after the next input change. Every sample is therefore taken in the middle of a clock phase.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int PRIO_W = 8;
  localparam int BP_W   = 3;
  localparam int REG_W  = 32;
  localparam logic [BP_W-1:0] BP_NO_PREEMPT = 3'd7;

  // floor of the binary point for a given count of implemented priority bits
  function automatic int floor_bp(input int prio_bits);
    int v;
    v = 7 - prio_bits;
    return (v < 0) ? 0 : v;
  endfunction

  // raise a requested setting to the floor
  function automatic logic [BP_W-1:0] clamp_bp(input logic [BP_W-1:0] req,
                                               input logic [BP_W-1:0] lo);
    return (req < lo) ? lo : req;
  endfunction
endpackage

// File: rtl/bp_store.sv
module bp_store
  import bp_pkg::*;
#(
  parameter logic [BP_W-1:0] MIN_BP = 3'd2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [BP_W-1:0] wr_val,
  output logic [BP_W-1:0] bp_q
);
  logic [BP_W-1:0] bp_next;

  assign bp_next = clamp_bp(wr_val, MIN_BP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bp_q <= MIN_BP;
    else if (wr_en) bp_q <= bp_next;
  end
endmodule

// File: rtl/bp_mask_gen.sv
module bp_mask_gen
  import bp_pkg::*;
(
  input  logic [BP_W-1:0]   bp,
  output logic [PRIO_W-1:0] mask
);
  for (genvar i = 0; i < PRIO_W; i++) begin : g_bit
    localparam logic [3:0] IDX = 4'(i);
    // a bit belongs to the group part when it sits above the binary point
    assign mask[i] = (IDX > {1'b0, bp});
  end
endmodule

// File: rtl/bp_preempt_cmp.sv
module bp_preempt_cmp
  import bp_pkg::*;
(
  input  logic [BP_W-1:0]   bp,
  input  logic [PRIO_W-1:0] mask,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] run_prio,
  output logic [PRIO_W-1:0] pend_grp,
  output logic [PRIO_W-1:0] run_grp,
  output logic              preempt
);
  logic grp_lower;

  assign pend_grp  = pend_prio & mask;
  assign run_grp   = run_prio & mask;
  assign grp_lower = (pend_grp < run_grp);
  assign preempt   = grp_lower && (bp != BP_NO_PREEMPT);
endmodule

// File: rtl/bp_split_reg.sv
module bp_split_reg
  import bp_pkg::*;
#(
  parameter int PRIO_BITS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  input  logic [7:0]  pend_prio,
  input  logic [7:0]  run_prio,
  output logic [7:0]  grp_mask,
  output logic        preempt
);
  localparam logic [BP_W-1:0] MIN_BP = BP_W'(floor_bp(PRIO_BITS));

  logic [BP_W-1:0]   bp_q;
  logic [PRIO_W-1:0] pend_grp;
  logic [PRIO_W-1:0] run_grp;
  logic              unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:BP_W];

  bp_store #(.MIN_BP(MIN_BP)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_val (wr_data[BP_W-1:0]),
    .bp_q   (bp_q)
  );

  bp_mask_gen u_mask (
    .bp   (bp_q),
    .mask (grp_mask)
  );

  bp_preempt_cmp u_cmp (
    .bp        (bp_q),
    .mask      (grp_mask),
    .pend_prio (pend_prio),
    .run_prio  (run_prio),
    .pend_grp  (pend_grp),
    .run_grp   (run_grp),
    .preempt   (preempt)
  );

  assign rd_data = rd_en ? {{(REG_W-BP_W){1'b0}}, bp_q} : '0;
endmodule

// File: rtl/bp_split_chk.sv
module bp_split_chk
  import bp_pkg::*;
#(
  parameter logic [BP_W-1:0] MIN_BP = 3'd2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [31:0]       rd_data,
  input logic [BP_W-1:0]   bp_q,
  input logic [PRIO_W-1:0] grp_mask,
  input logic [PRIO_W-1:0] pend_grp,
  input logic [PRIO_W-1:0] run_grp,
  input logic              preempt
);
  a_r1_floor_held: assert property (@(posedge clk) disable iff (!rst_n)
    bp_q >= MIN_BP);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2:0] >= MIN_BP) |=> bp_q == $past(wr_data[2:0]));

  a_r3_write_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2:0] < MIN_BP) |=> bp_q == MIN_BP);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:3] == '0);

  a_r5_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  a_r6_sub_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_q != 3'd7) |-> ((grp_mask & ~(8'hFE << bp_q)) == 8'h00) && grp_mask[7]);

  a_r8_equal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_grp == run_grp) |-> !preempt);

  a_r9_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_q == 3'd7) |-> !preempt);

  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bp_q));
endmodule

bind bp_split_reg bp_split_chk #(.MIN_BP(MIN_BP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .bp_q     (bp_q),
  .grp_mask (grp_mask),
  .pend_grp (pend_grp),
  .run_grp  (run_grp),
  .preempt  (preempt)
);

// File: tb/sim_bp_split_reg.sv
`timescale 1ns/1ps
module sim_bp_split_reg;
  localparam int PRIO_BITS = 5;
  localparam int HALF = 10;

  typedef struct {
    int          req;
    int          sel;   // 0 rd_data, 1 grp_mask, 2 preempt
    logic [31:0] exp;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1;
  logic [31:0] rd_data;
  logic [7:0]  pend_prio = '0;
  logic [7:0]  run_prio = '0;
  logic [7:0]  grp_mask;
  logic        preempt;

  int    n_chk = 0;
  int    n_fail = 0;
  item_t sb[$];
  event  chk_ev;
  bit    done = 0;

  always #HALF clk = ~clk;

  bp_split_reg #(.PRIO_BITS(PRIO_BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pend_prio(pend_prio),
    .run_prio(run_prio), .grp_mask(grp_mask), .preempt(preempt)
  );

  // model, written independently of the design
  function automatic int model_floor();
    return (PRIO_BITS >= 7) ? 0 : 7 - PRIO_BITS;
  endfunction

  function automatic logic [7:0] model_mask(input int n);
    logic [7:0] m;
    m = '0;
    for (int b = 7; b > n; b--) m[b] = 1'b1;
    return m;
  endfunction

  function automatic int model_store(input int req);
    return (req < model_floor()) ? model_floor() : req;
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.sel)
          0: act = rd_data;
          1: act = {24'h0, grp_mask};
          default: act = {31'h0, preempt};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_out(input int req, input int sel, input logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic settle_and_check();
    #2;
    -> chk_ev;
    #1;
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic check_prio(input int req, input logic [7:0] p, input logic [7:0] r,
                            input bit exp);
    @(negedge clk);
    pend_prio = p; run_prio = r;
    expect_out(req, 2, {31'h0, exp});
    settle_and_check();
  endtask

  initial begin
    // R1: reset state
    #(3*HALF);
    expect_out(1, 0, model_floor());
    expect_out(6, 1, model_mask(model_floor()));
    settle_and_check();
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    expect_out(1, 0, model_floor());
    settle_and_check();

    // R2: legal write
    do_write(32'h5);
    expect_out(2, 0, 32'h5);
    expect_out(6, 1, model_mask(5));
    settle_and_check();

    // R3: writes below the floor
    do_write(32'h0);
    expect_out(3, 0, model_floor());
    settle_and_check();
    do_write(32'h1);
    expect_out(3, 0, model_floor());
    settle_and_check();

    // R4: upper bits ignored
    do_write(32'hFFFF_FFF4);
    expect_out(4, 0, 32'h4);
    settle_and_check();

    // R5: no read request gives zero, then same-cycle read
    @(negedge clk); rd_en = 0;
    expect_out(5, 0, 32'h0);
    settle_and_check();
    @(negedge clk); rd_en = 1;
    expect_out(5, 0, 32'h4);
    settle_and_check();

    // R10: data without strobe is ignored
    @(negedge clk); wr_data = 32'h6;
    @(negedge clk);
    expect_out(10, 0, 32'h4);
    settle_and_check();

    // R7 / R8 at setting 4 (mask E0)
    check_prio(7, 8'h20, 8'h40, 1'b1);
    check_prio(7, 8'h40, 8'h20, 1'b0);
    check_prio(8, 8'h25, 8'h3F, 1'b0);

    // R9 and R6 at setting 7
    do_write(32'h7);
    expect_out(6, 1, 32'h0);
    settle_and_check();
    check_prio(9, 8'h00, 8'hFF, 1'b0);

    // setting 2 (mask F8)
    do_write(32'h2);
    check_prio(8, 8'h10, 8'h14, 1'b0);
    check_prio(7, 8'h08, 8'h10, 1'b1);

    // sweep every request value
    for (int v = 0; v < 8; v++) begin
      do_write(32'(v));
      expect_out(2, 0, model_store(v));
      expect_out(6, 1, model_mask(model_store(v)));
      settle_and_check();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(2*HALF*100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule